// File: doc/BRIEF.md
# Clamp and Preblank Pulse Generator

This block produces two per-line timing strobes for an image sensor front end. One is an optical-black clamp strobe and the other is a preblank strobe. Both are active low. A pixel counter restarts on every rising edge of the horizontal sync input. Each strobe has three settings: a level it takes at the start of every line, and two pixel positions at which it inverts. These settings are enough to place a single active window anywhere in the line, or a window that wraps around the line start.

A line counter restarts on the rising edge of the vertical sync input and advances on each horizontal sync. Two programmable inclusive line ranges suppress the clamp strobe: on any line inside either range, the clamp output is held high for the whole line. The preblank strobe has no line suppression. All inputs are sampled on the pixel clock, and both outputs come straight from flip-flops.

Top module: `clamp_blank_gen`

## Requirements
- R1: After reset, both outputs are high, and they stay high until the first horizontal sync rising edge, whatever the settings.
- R2: When the clock samples a rising edge of `hsync`, each output takes its start-level setting on that clock edge. The following cycle is pixel 0 of the line.
- R3: On each output, an inversion occurs on the clock edge that ends pixel N, for each of its two toggle positions N. So after the edge that ends pixel k-1, the level seen during pixel k is the start level, inverted once for each position below k.
- R4: Two equal toggle positions on the same output produce a single inversion, not two.
- R5: A toggle position that the line never reaches never fires, and the output holds its level. The all-ones position (8191 for the default 13-bit width) never fires on any line.
- R6: A sampled `vsync` rising edge makes the line number 0. The line started by a coincident `hsync` edge is line 0, and each later `hsync` edge adds one to the line number.
- R7: On every line whose number lies inside range A or range B, bounds included, `clamp_n` is high for the entire line.
- R8: A range whose first line equals its last line suppresses the clamp on that one line only.
- R9: A range whose first line is greater than its last line suppresses nothing.
- R10: The line ranges never affect `pblank_n`.
- R11: An `hsync` edge in the middle of a line restarts both patterns from pixel 0, regardless of the state they were in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| vsync | input | 1 | Vertical sync; its rising edge restarts the line count |
| clamp_start_lvl | input | 1 | Clamp level at line start |
| clamp_tog_a | input | 13 | Clamp first toggle pixel |
| clamp_tog_b | input | 13 | Clamp second toggle pixel |
| pblank_start_lvl | input | 1 | Preblank level at line start |
| pblank_tog_a | input | 13 | Preblank first toggle pixel |
| pblank_tog_b | input | 13 | Preblank second toggle pixel |
| rng_a_first | input | 12 | First line of suppression range A |
| rng_a_last | input | 12 | Last line of suppression range A |
| rng_b_first | input | 12 | First line of suppression range B |
| rng_b_last | input | 12 | Last line of suppression range B |
| clamp_n | output | 1 | Clamp strobe, active low |
| pblank_n | output | 1 | Preblank strobe, active low |

## Verification
The bench compares every pixel against a model for many settings: toggle positions in reversed order, equal positions, positions at pixel 0, positions beyond the line length, and the disabled all-ones position. A design that lets an equal pair cancel out, or that wraps the pixel counter, shows the wrong level there.

For line suppression, the bench runs a frame through lines 6 to 8 and through single line 600. It then uses a reversed range. An off-by-one range compare, a mask taken from the previous line number, or an empty range treated as full shows up as a wrong first pixel or a wrong edge line.

The bench also cuts lines short and sends a sync edge from reset. This exposes stale toggle state and any toggle that fires before the first line.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int PIX_W_DEF   = 13;
  localparam int LINE_W_DEF  = 12;
  localparam int N_RANGE_DEF = 2;
endpackage

// File: rtl/cbg_timebase.sv
module cbg_timebase #(
  parameter int PIX_W  = cbg_pkg::PIX_W_DEF,
  parameter int LINE_W = cbg_pkg::LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              vsync,
  output logic              line_start,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_nxt
);
  localparam logic [PIX_W-1:0]  PIX_SAT  = '1;
  localparam logic [LINE_W-1:0] LINE_SAT = '1;

  logic              hs_q, vs_q, frame_start;
  logic [LINE_W-1:0] line_q;

  assign line_start  = hsync & ~hs_q;
  assign frame_start = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
    end
  end

  // Pixel counter saturates so that toggles cannot refire on overlong lines.
  always_ff @(posedge clk) begin
    if (rst)                  pix_q <= PIX_SAT;
    else if (line_start)      pix_q <= '0;
    else if (pix_q != PIX_SAT) pix_q <= pix_q + 1'b1;
  end

  always_comb begin
    if (frame_start)                            line_nxt = '0;
    else if (line_start && line_q != LINE_SAT)  line_nxt = line_q + 1'b1;
    else                                        line_nxt = line_q;
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_nxt;
  end

  p_pix_restart_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> pix_q == '0);
  p_pix_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!line_start && pix_q != PIX_SAT) |=> (pix_q - $past(pix_q)) == PIX_W'(1));
  p_frame_restart_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> line_q == '0);
endmodule

// File: rtl/cbg_toggle_pulse.sv
module cbg_toggle_pulse #(
  parameter int PIX_W = cbg_pkg::PIX_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [PIX_W-1:0] pix,
  input  logic             start_lvl,
  input  logic [PIX_W-1:0] tog_a,
  input  logic [PIX_W-1:0] tog_b,
  input  logic             force_hi,
  output logic             out_q
);
  localparam logic [PIX_W-1:0] PIX_SAT = '1;

  logic level_q, level_d, hit;

  // A saturated count never matches, so the all-ones position is inert.
  assign hit = (pix != PIX_SAT) && ((pix == tog_a) || (pix == tog_b));

  always_comb begin
    if (line_start) level_d = start_lvl;
    else if (hit)   level_d = ~level_q;
    else            level_d = level_q;
  end

  // level_q keeps running through forced lines; out_q is what leaves the block.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      out_q   <= 1'b1;
    end else begin
      level_q <= level_d;
      out_q   <= level_d | force_hi;
    end
  end

  p_line_start_level_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> level_q == $past(start_lvl));
  p_hold_without_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (!line_start && !hit) |=> $stable(level_q));
  p_force_high_r7: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> out_q);
endmodule

// File: rtl/cbg_line_mask.sv
module cbg_line_mask #(
  parameter int LINE_W  = cbg_pkg::LINE_W_DEF,
  parameter int N_RANGE = cbg_pkg::N_RANGE_DEF
) (
  input  logic [LINE_W-1:0]         line,
  input  logic [N_RANGE*LINE_W-1:0] first_flat,
  input  logic [N_RANGE*LINE_W-1:0] last_flat,
  output logic                      hit
);
  logic [N_RANGE-1:0] in_rng;

  for (genvar i = 0; i < N_RANGE; i++) begin : g_rng
    logic [LINE_W-1:0] lo, hi;
    assign lo        = first_flat[i*LINE_W +: LINE_W];
    assign hi        = last_flat[i*LINE_W +: LINE_W];
    // Inclusive bounds; lo > hi yields an empty range.
    assign in_rng[i] = (line >= lo) && (line <= hi);
  end

  assign hit = |in_rng;
endmodule

// File: rtl/clamp_blank_gen.sv
module clamp_blank_gen #(
  parameter int PIX_W  = cbg_pkg::PIX_W_DEF,
  parameter int LINE_W = cbg_pkg::LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              clamp_start_lvl,
  input  logic [PIX_W-1:0]  clamp_tog_a,
  input  logic [PIX_W-1:0]  clamp_tog_b,
  input  logic              pblank_start_lvl,
  input  logic [PIX_W-1:0]  pblank_tog_a,
  input  logic [PIX_W-1:0]  pblank_tog_b,
  input  logic [LINE_W-1:0] rng_a_first,
  input  logic [LINE_W-1:0] rng_a_last,
  input  logic [LINE_W-1:0] rng_b_first,
  input  logic [LINE_W-1:0] rng_b_last,
  output logic              clamp_n,
  output logic              pblank_n
);
  localparam int N_RANGE = cbg_pkg::N_RANGE_DEF;

  logic              line_start, mask_hit;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line_nxt;

  cbg_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_tb (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .line_start(line_start), .pix_q(pix), .line_nxt(line_nxt)
  );

  // Mask is judged on the line number that is current after this edge.
  cbg_line_mask #(.LINE_W(LINE_W), .N_RANGE(N_RANGE)) u_mask (
    .line(line_nxt),
    .first_flat({rng_b_first, rng_a_first}),
    .last_flat({rng_b_last, rng_a_last}),
    .hit(mask_hit)
  );

  cbg_toggle_pulse #(.PIX_W(PIX_W)) u_clamp (
    .clk(clk), .rst(rst), .line_start(line_start), .pix(pix),
    .start_lvl(clamp_start_lvl), .tog_a(clamp_tog_a), .tog_b(clamp_tog_b),
    .force_hi(mask_hit), .out_q(clamp_n)
  );

  cbg_toggle_pulse #(.PIX_W(PIX_W)) u_pblank (
    .clk(clk), .rst(rst), .line_start(line_start), .pix(pix),
    .start_lvl(pblank_start_lvl), .tog_a(pblank_tog_a), .tog_b(pblank_tog_b),
    .force_hi(1'b0), .out_q(pblank_n)
  );

  p_mask_holds_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    mask_hit |=> clamp_n);
endmodule

// File: tb/clamp_blank_gen_test.sv
module clamp_blank_gen_test;
  typedef struct packed {
    logic        lvl;
    logic [12:0] ta;
    logic [12:0] tb;
  } vec_t;

  // Pulse configurations walked over one 16-pixel line each.
  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 13'd2,    13'd9},
    '{1'b1, 13'd0,    13'd5},
    '{1'b0, 13'd11,   13'd3},
    '{1'b1, 13'd6,    13'd6},
    '{1'b0, 13'd4,    13'd100},
    '{1'b1, 13'd8191, 13'd8191},
    '{1'b0, 13'd15,   13'd0}
  };

  logic clk = 1'b0, rst = 1'b1, hsync = 1'b0, vsync = 1'b0;
  logic        c_lvl = 1'b0, p_lvl = 1'b1;
  logic [12:0] c_ta = 13'd0, c_tb = 13'd1, p_ta = 13'd2, p_tb = 13'd3;
  logic [11:0] a_f = 12'd1, a_l = 12'd0, b_f = 12'd1, b_l = 12'd0;
  logic clamp_n, pblank_n;

  int n_chk = 0, n_fail = 0, cur_line = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clamp_blank_gen uut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .clamp_start_lvl(c_lvl), .clamp_tog_a(c_ta), .clamp_tog_b(c_tb),
    .pblank_start_lvl(p_lvl), .pblank_tog_a(p_ta), .pblank_tog_b(p_tb),
    .rng_a_first(a_f), .rng_a_last(a_l), .rng_b_first(b_f), .rng_b_last(b_l),
    .clamp_n(clamp_n), .pblank_n(pblank_n)
  );

  function automatic logic model_lvl(logic lvl, int ta, int tb, int k);
    logic v = lvl;
    if (ta != 8191 && ta < k) v = ~v;
    if (tb != 8191 && tb != ta && tb < k) v = ~v;
    return v;
  endfunction

  function automatic bit masked(int ln);
    return (ln >= int'(a_f) && ln <= int'(a_l)) || (ln >= int'(b_f) && ln <= int'(b_l));
  endfunction

  task automatic check(logic act, logic exp, string req, int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line %0d pixel %0d: actual %b expected %b", req, cur_line, k, act, exp);
    end
  endtask

  // Starts a line with an hsync edge (optionally with vsync) and checks len pixels.
  task automatic run_line(int len, bit with_vs, string creq);
    @(negedge clk);
    hsync = 1'b1;
    vsync = with_vs;
    if (with_vs) cur_line = 0;
    else if (cur_line < 4095) cur_line++;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      hsync = 1'b0;
      vsync = 1'b0;
      check(clamp_n, masked(cur_line) ? 1'b1 : model_lvl(c_lvl, c_ta, c_tb, k), creq, k);
      check(pblank_n, model_lvl(p_lvl, p_ta, p_tb, k), "R10", k);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: toggles at pixels 0..3 must not fire before the first line.
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(clamp_n, 1'b1, "R1", i);
      check(pblank_n, 1'b1, "R1", i);
    end

    // R2 R3 R4 R5: vector table over one line each.
    for (int v = 0; v < NVEC; v++) begin
      c_lvl = VEC[v].lvl;  c_ta = VEC[v].ta;  c_tb = VEC[v].tb;
      p_lvl = ~VEC[v].lvl; p_ta = VEC[v].tb;  p_tb = VEC[v].ta;
      run_line(16, 1'b1, (VEC[v].ta == VEC[v].tb) ? "R4" : (v >= 4 ? "R5" : "R3"));
    end

    // R11: cut a line short mid-pattern, then a full line restarts at pixel 0.
    c_lvl = 1'b1; c_ta = 13'd2; c_tb = 13'd7;
    p_lvl = 1'b0; p_ta = 13'd1; p_tb = 13'd3;
    run_line(4, 1'b1, "R11");
    run_line(3, 1'b0, "R11");
    run_line(12, 1'b0, "R11");

    // R6 R7 R8: range A = 6..8, range B = single line 600.
    c_lvl = 1'b0; c_ta = 13'd2; c_tb = 13'd6;
    a_f = 12'd6;   a_l = 12'd8;
    b_f = 12'd600; b_l = 12'd600;
    run_line(10, 1'b1, "R6");
    for (int ln = 1; ln <= 602; ln++)
      run_line(10, 1'b0,
               (ln >= 5 && ln <= 9) ? "R7" : ((ln >= 599) ? "R8" : "R6"));

    // R9: reversed range A masks nothing, range B back to empty.
    a_f = 12'd20; a_l = 12'd10;
    b_f = 12'd1;  b_l = 12'd0;
    run_line(10, 1'b1, "R9");
    for (int ln = 1; ln <= 24; ln++) run_line(10, 1'b0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule